// File: doc/BRIEF.md
# Byte-Wide Chained Configuration Loader

This block loads a configuration image into a small local memory, one byte on every rising edge of a configuration clock that an outside source drives. Several loaders can share the clock and the 8-bit data bus. Each loader's status output feeds the chip-select input of the next loader in the chain, so only one device stores frame data at any time. The chip-select of the first device is tied high.

Each loader reads a two-byte header that all devices in the chain see at the same time. It then stores frame bytes while it is selected. Every frame ends in a fixed closing byte, and the loader checks that byte. When its memory is full, the loader raises its status output so that the next device takes the bus. The loader does not check a CRC and keeps no length count. The memory filling up is the only signal that loading is complete.

Each device releases an open-drain-style DONE line once it is full. The devices share the resulting wired-AND level. A device turns on its user logic only when that shared level is high, so all devices in the chain start up together.

Top module: `cfg_chain_loader`

## Requirements
- R1: After reset is released, the first clock edge is a wake-up edge and its byte is ignored. The first header byte is sampled on the second rising edge, and each later byte is sampled on the next rising edge.
- R2: The header is two fixed bytes, 8'hAA followed by 8'h99. If either byte does not match, the device enters a sticky error state.
- R3: A frame is FRAME_BYTES data bytes followed by the closing byte 8'h3C. A wrong closing byte on a frame being stored causes the sticky error state.
- R4: Stored data bytes go to memory addresses 0, 1, 2 and onward, in arrival order. The device becomes full only after it accepts the closing byte of frame NUM_FRAMES-1. No length count is used.
- R5: Frame bytes (data and closing) are ignored while chip-select is low and after the device is full. In both cases the memory does not change.
- R6: The status output is high during reset and during the header. It goes low from the edge that accepts a valid second header byte. It goes high again from the edge that makes the device full.
- R7: The error state is permanent until reset. In the error state, no memory writes occur, the status output stays low and DONE stays held low. Memory contents are never cleared by reset.
- R8: The doneRelease output is 1 (DONE line released) only when the device is full with no error. Otherwise it is 0 (line driven low).
- R9: userActive is 0 after reset. It becomes 1 on the first edge at which the device is full and the shared DONE input is high, and it then stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfgClk | input | 1 | Configuration clock driven from outside; bytes are sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset; releasing it starts configuration |
| csIn | input | 1 | Chip-select from the previous device's status output (tied high on the first device) |
| dataIn | input | 8 | Shared configuration byte bus |
| statusOut | output | 1 | Low while the device is filling; high hands the bus to the next device |
| doneRelease | output | 1 | 1 releases the shared DONE line, 0 drives it low |
| doneIn | input | 1 | Level of the shared DONE net |
| userActive | output | 1 | User logic enable, set when the shared DONE level is high |
| errFlag | output | 1 | Sticky constant-field error |
| rdAddr | input | AW | Read address into the configuration memory model |
| rdData | output | 8 | Memory byte at rdAddr |

## Verification
The bench builds a chain of three loaders and compares each memory against that device's slice of a random stream. The byte on the wake-up edge is chosen so it never matches the header; a loader that samples one edge too early would therefore enter the error state at once. A handoff between devices that is off by one edge would move a byte into the wrong device, and the memory comparison would show it. A corrupted closing byte in the middle device must stop that device's writes, leave the last device's memory unchanged, and keep the shared DONE low. Extra bytes sent after the whole chain is full must leave every memory unchanged. The user-logic enable is checked to rise only one edge after the last device releases DONE.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  typedef enum logic [2:0] {
    ST_WAKE  = 3'd0,
    ST_HDR0  = 3'd1,
    ST_HDR1  = 3'd2,
    ST_DATA  = 3'd3,
    ST_TRAIL = 3'd4,
    ST_FULL  = 3'd5,
    ST_ERR   = 3'd6
  } ldState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrByte;     // store dataIn at the write pointer
    logic nextFrame;  // closing byte accepted, move to next frame
    logic clrPtr;     // header done, clear the pointers
  } ldStrobe_t;

endpackage

// File: rtl/cfg_loader_dp.sv
module cfg_loader_dp
  import cfg_loader_pkg::*;
#(
  parameter int FRAME_BYTES = 4,
  parameter int NUM_FRAMES  = 2,
  parameter logic [7:0] PRE_BYTE   = 8'hAA,
  parameter logic [7:0] SYNC_BYTE  = 8'h99,
  parameter logic [7:0] TRAIL_BYTE = 8'h3C,
  localparam int DEPTH = FRAME_BYTES * NUM_FRAMES,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [7:0]    dataIn,
  input  ldStrobe_t     stb,
  input  logic [AW-1:0] rdAddr,
  output logic [7:0]    rdData,
  output logic          lastByte,
  output logic          lastFrame,
  output logic          isPre,
  output logic          isSync,
  output logic          isTrail
);

  localparam int BW = (FRAME_BYTES > 1) ? $clog2(FRAME_BYTES) : 1;
  localparam int FW = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1;
  localparam logic [BW-1:0] LAST_B = BW'(FRAME_BYTES - 1);
  localparam logic [FW-1:0] LAST_F = FW'(NUM_FRAMES - 1);
  localparam logic [AW:0]   DEPTH_W = (AW+1)'(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wrAddr;
  logic [BW-1:0] byteIdx;
  logic [FW-1:0] frameIdx;

  assign isPre   = (dataIn == PRE_BYTE);
  assign isSync  = (dataIn == SYNC_BYTE);
  assign isTrail = (dataIn == TRAIL_BYTE);
  assign lastByte  = (byteIdx == LAST_B);
  assign lastFrame = (frameIdx == LAST_F);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrAddr   <= '0;
      byteIdx  <= '0;
      frameIdx <= '0;
    end else if (stb.clrPtr) begin
      wrAddr   <= '0;
      byteIdx  <= '0;
      frameIdx <= '0;
    end else begin
      if (stb.wrByte) begin
        wrAddr  <= wrAddr + 1'b1;
        byteIdx <= lastByte ? '0 : byteIdx + 1'b1;
      end
      if (stb.nextFrame) frameIdx <= frameIdx + 1'b1;
    end
  end

  // Memory model is not cleared by reset
  always_ff @(posedge clk) begin
    if (stb.wrByte) mem[wrAddr] <= dataIn;
  end

  assign rdData = ({1'b0, rdAddr} < DEPTH_W) ? mem[rdAddr] : 8'h00;

  a_r4_addr_in_range: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrByte |-> ({1'b0, wrAddr} < DEPTH_W));

  a_r3_frame_closes_on_boundary: assert property (@(posedge clk) disable iff (!rstN)
    stb.nextFrame |-> (byteIdx == '0));

endmodule

// File: rtl/cfg_loader_ctrl.sv
module cfg_loader_ctrl
  import cfg_loader_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      csIn,
  input  logic      doneIn,
  input  logic      isPre,
  input  logic      isSync,
  input  logic      isTrail,
  input  logic      lastByte,
  input  logic      lastFrame,
  output ldStrobe_t stb,
  output logic      statusOut,
  output logic      doneRelease,
  output logic      userActive,
  output logic      errFlag
);

  ldState_e state, nextState;

  always_comb begin
    nextState = state;
    stb       = '0;
    unique case (state)
      ST_WAKE: nextState = ST_HDR0;
      ST_HDR0: nextState = isPre ? ST_HDR1 : ST_ERR;
      ST_HDR1: begin
        if (isSync) begin
          nextState  = ST_DATA;
          stb.clrPtr = 1'b1;
        end else begin
          nextState = ST_ERR;
        end
      end
      ST_DATA: begin
        if (csIn) begin
          stb.wrByte = 1'b1;
          if (lastByte) nextState = ST_TRAIL;
        end
      end
      ST_TRAIL: begin
        if (csIn) begin
          if (!isTrail) begin
            nextState = ST_ERR;
          end else if (lastFrame) begin
            nextState = ST_FULL;
          end else begin
            nextState     = ST_DATA;
            stb.nextFrame = 1'b1;
          end
        end
      end
      ST_FULL: nextState = ST_FULL;
      ST_ERR:  nextState = ST_ERR;
      default: nextState = ST_ERR;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_WAKE;
      userActive <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_FULL && doneIn) userActive <= 1'b1;
    end
  end

  assign statusOut   = !(state == ST_DATA || state == ST_TRAIL || state == ST_ERR);
  assign doneRelease = (state == ST_FULL);
  assign errFlag     = (state == ST_ERR);

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  a_r7_no_write_in_err: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> !stb.wrByte);

  a_r5_write_needs_select: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrByte |-> csIn);

  a_r6_status_rises_when_full: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusOut) |-> doneRelease);

  a_r9_user_after_shared_done: assert property (@(posedge clk) disable iff (!rstN)
    $rose(userActive) |-> ($past(doneIn) && $past(doneRelease)));

  a_r8_no_release_with_err: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> !doneRelease);

endmodule

// File: rtl/cfg_chain_loader.sv
module cfg_chain_loader
  import cfg_loader_pkg::*;
#(
  parameter int FRAME_BYTES = 4,
  parameter int NUM_FRAMES  = 2,
  parameter logic [7:0] PRE_BYTE   = 8'hAA,
  parameter logic [7:0] SYNC_BYTE  = 8'h99,
  parameter logic [7:0] TRAIL_BYTE = 8'h3C,
  localparam int DEPTH = FRAME_BYTES * NUM_FRAMES,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          cfgClk,
  input  logic          rstN,
  input  logic          csIn,
  input  logic [7:0]    dataIn,
  output logic          statusOut,
  output logic          doneRelease,
  input  logic          doneIn,
  output logic          userActive,
  output logic          errFlag,
  input  logic [AW-1:0] rdAddr,
  output logic [7:0]    rdData
);

  ldStrobe_t stb;
  logic lastByte, lastFrame, isPre, isSync, isTrail;

  cfg_loader_ctrl u_ctrl (
    .clk(cfgClk), .rstN(rstN), .csIn(csIn), .doneIn(doneIn),
    .isPre(isPre), .isSync(isSync), .isTrail(isTrail),
    .lastByte(lastByte), .lastFrame(lastFrame), .stb(stb),
    .statusOut(statusOut), .doneRelease(doneRelease),
    .userActive(userActive), .errFlag(errFlag)
  );

  cfg_loader_dp #(
    .FRAME_BYTES(FRAME_BYTES), .NUM_FRAMES(NUM_FRAMES),
    .PRE_BYTE(PRE_BYTE), .SYNC_BYTE(SYNC_BYTE), .TRAIL_BYTE(TRAIL_BYTE)
  ) u_dp (
    .clk(cfgClk), .rstN(rstN), .dataIn(dataIn), .stb(stb),
    .rdAddr(rdAddr), .rdData(rdData),
    .lastByte(lastByte), .lastFrame(lastFrame),
    .isPre(isPre), .isSync(isSync), .isTrail(isTrail)
  );

endmodule

// File: tb/sim_cfg_chain_loader.sv
`timescale 1ns/1ps
module sim_cfg_chain_loader;

  localparam int FB = 4;
  localparam int NF = 2;
  localparam int DEPTH = FB * NF;
  localparam int ND = 3;
  localparam logic [7:0] PRE = 8'hAA;
  localparam logic [7:0] SYN = 8'h99;
  localparam logic [7:0] TRL = 8'h3C;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN;
  logic [7:0] dataIn;
  logic [2:0] rdAddr;
  logic [ND-1:0] st, rel, ua, er;
  logic [7:0] rd [ND];
  logic sharedDone;
  assign sharedDone = &rel;

  logic [7:0] expMem [ND*DEPTH];
  int tests = 0;
  int fails = 0;

  cfg_chain_loader u0 (.cfgClk(clk), .rstN(rstN), .csIn(1'b1), .dataIn(dataIn),
    .statusOut(st[0]), .doneRelease(rel[0]), .doneIn(sharedDone),
    .userActive(ua[0]), .errFlag(er[0]), .rdAddr(rdAddr), .rdData(rd[0]));
  cfg_chain_loader u1 (.cfgClk(clk), .rstN(rstN), .csIn(st[0]), .dataIn(dataIn),
    .statusOut(st[1]), .doneRelease(rel[1]), .doneIn(sharedDone),
    .userActive(ua[1]), .errFlag(er[1]), .rdAddr(rdAddr), .rdData(rd[1]));
  cfg_chain_loader u2 (.cfgClk(clk), .rstN(rstN), .csIn(st[1]), .dataIn(dataIn),
    .statusOut(st[2]), .doneRelease(rel[2]), .doneIn(sharedDone),
    .userActive(ua[2]), .errFlag(er[2]), .rdAddr(rdAddr), .rdData(rd[2]));

  function automatic int slot(int d, int i);
    return d * DEPTH + i;
  endfunction

  function automatic logic [7:0] notHeader(logic [7:0] v);
    return (v == PRE) ? ~v : v;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic putByte(logic [7:0] b);
    @(negedge clk);
    dataIn = b;
  endtask

  // reset, check idle outputs, release; first edge gets a non-header byte (R1)
  task automatic startCfg();
    rstN = 1'b0;
    dataIn = 8'h00;
    repeat (2) @(negedge clk);
    #1;
    chk(st == 3'b111, "R6", "status in reset", int'(st), 7);
    chk(rel == 3'b000, "R8", "release in reset", int'(rel), 0);
    chk(ua == 3'b000 && er == 3'b000, "R9", "user/err in reset", int'({ua, er}), 0);
    @(negedge clk);
    rstN = 1'b1;
    dataIn = notHeader(8'($urandom));
  endtask

  task automatic sendDev(int d, int badFrame);
    for (int f = 0; f < NF; f++) begin
      for (int b = 0; b < FB; b++) begin
        logic [7:0] v;
        v = 8'($urandom);
        if (badFrame < 0 || f <= badFrame) expMem[slot(d, f*FB + b)] = v;
        putByte(v);
        if (f == 0 && b == 0) begin
          #1;
          chk(st == 3'((1 << d) - 1), "R6", "status at device start", int'(st), (1 << d) - 1);
          chk(er == 3'b000, "R1", "no error after header", int'(er), 0);
        end
      end
      putByte((f == badFrame) ? (TRL ^ 8'h01) : TRL);
    end
  endtask

  task automatic readBack(string req);
    for (int d = 0; d < ND; d++) begin
      for (int i = 0; i < DEPTH; i++) begin
        rdAddr = 3'(i);
        #1;
        chk(rd[d] === expMem[slot(d, i)], req, $sformatf("dev%0d mem[%0d]", d, i),
            int'(rd[d]), int'(expMem[slot(d, i)]));
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rdAddr = '0;

    // R1 R4 R5 R6 R8 R9: full chain, several random images
    for (int run = 0; run < 3; run++) begin
      startCfg();
      putByte(PRE);
      putByte(SYN);
      for (int d = 0; d < ND; d++) sendDev(d, -1);
      putByte(8'($urandom));  // after full: ignored (R5)
      #1;
      chk(rel == 3'b111, "R8", "all released", int'(rel), 7);
      chk(st == 3'b111, "R6", "status high when full", int'(st), 7);
      chk(ua == 3'b000, "R9", "user waits one edge", int'(ua), 0);
      putByte(TRL);
      #1;
      chk(ua == 3'b111, "R9", "user enabled together", int'(ua), 7);
      repeat (3) putByte(8'($urandom));
      @(negedge clk);
      readBack("R4");
    end

    // R3 R7: bad closing byte on the middle device
    startCfg();
    putByte(PRE);
    putByte(SYN);
    sendDev(0, -1);
    sendDev(1, 0);
    repeat (4) putByte(8'($urandom));
    @(negedge clk);
    #1;
    chk(er == 3'b010, "R3", "error on bad closing byte", int'(er), 2);
    chk(st[2:1] == 2'b00, "R7", "status low in error", int'(st[2:1]), 0);
    chk(rel == 3'b001, "R7", "release only dev0", int'(rel), 1);
    chk(ua == 3'b000, "R9", "no user without shared done", int'(ua), 0);
    readBack("R7");

    // R2: bad first header byte
    startCfg();
    putByte(PRE ^ 8'h10);
    putByte(SYN);
    #1;
    chk(er == 3'b111, "R2", "header mismatch error", int'(er), 7);
    chk(st == 3'b000, "R2", "status low after header error", int'(st), 0);
    repeat (10) putByte(8'($urandom));
    #1;
    chk(rel == 3'b000, "R7", "done held low in error", int'(rel), 0);
    readBack("R5");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule